// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the bus-facing register file of a serial port. A host reaches it through a 32-bit, word-addressed interface with separate read and write strobes and a 4 KB byte window. The block holds the baud divisors, the line and control settings, the FIFO level selection and the DMA control. It also keeps a raw interrupt status word, an interrupt mask and the masked view of the two, and it drives a single level-sensitive interrupt line.

A write to the data register hands the low byte to the transmit side over a valid/ready port and marks a transmit interrupt at once. A receive-side event input marks the receive interrupt. The top eight words of the window return a constant set of eight identification bytes, one byte per word, and a parameter picks which of two tables is served. Any access to an offset that the block does not decode produces an error strobe in the same cycle. So does a DMA-control write that sets either of the two request-enable bits. The serial shifter, baud timing and DMA engine live outside this block.

Top module: `uart_regif`

## Requirements
- R1: After reset the control register (word 12) reads 0x300, the FIFO level register (word 13) reads 0x12, every other storage register, the raw status and the mask read 0, and irq_o and tx_valid_o are low.
- R2: The configuration registers are read/write at word indices 8 (low-power divisor, 8 bits), 9 (integer divisor, 16 bits), 10 (fractional divisor, 6 bits), 11 (line control, 8 bits), 12 (control, 16 bits), 13 (FIFO level, 6 bits) and 18 (DMA control, 3 bits). A read returns the last written value truncated to that width, with the upper bits zero.
- R3: A write to word 0 places wdata_i[7:0] on tx_data_o and raises tx_valid_o from the next cycle. tx_valid_o and tx_data_o hold until a cycle with tx_ready_i high, after which tx_valid_o drops. The same write sets raw status bit 5 (transmit).
- R4: A cycle with rx_event_i high sets raw status bit 4 (receive).
- R5: Word 14 is an 11-bit read/write interrupt mask. Word 15 reads the raw status. Word 16 reads the raw status ANDed with the mask.
- R6: A write to word 17 clears each raw status bit whose position is set in the written value. A receive event in the same cycle keeps bit 4 set.
- R7: irq_o is registered. It is high exactly when the raw status ANDed with the mask is nonzero, and it changes in the same cycle as the status or mask registers, one cycle after the causing write.
- R8: Byte offsets 0xFE0 to 0xFFC read the identification byte at index (offset − 0xFE0) >> 2. With the default table selection these bytes are 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 for indices 0 to 7.
- R9: Word 0 and word 1 read zero. Word 6 reads status_flags_i zero-extended, and writes to word 6 and word 1 are accepted without error and change nothing.
- R10: A read of an undecoded word or of word 17, or a write to an undecoded word, word 15, word 16 or the identification window, raises err_o in that cycle. Such a read returns zero and such a write changes no state. A write to word 18 with wdata_i[1:0] nonzero also raises err_o and still stores the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte offset in the register window |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of rd_en_i |
| err_o | output | 1 | Error strobe for bad accesses and DMA enable writes |
| status_flags_i | input | 8 | Flag bits supplied by the FIFO side, read at word 6 |
| rx_event_i | input | 1 | Receive-side interrupt request |
| tx_data_o | output | 8 | Transmit byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmit side accepts the byte |
| irq_o | output | 1 | Level-sensitive interrupt |

## Verification
The address decode is exercised by reading every one of the 1024 word offsets. This separates decoded words, write-only words, the identification window and holes by their error strobe and their read data. Each configuration register is driven with all-ones, two alternating patterns, zero and a walking one, which exposes wrong widths, stuck bits and cross-register aliasing. The interrupt path is walked through all sixteen combinations of the two source bits against the two mask bits, so that raw, masked and line values must agree. Separate cases cover partial clears, a clear racing a receive event, and the one-cycle lag of the line.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IRQ_W  = 11;
  localparam int unsigned IRQ_RX = 4;
  localparam int unsigned IRQ_TX = 5;

  localparam int unsigned LPDIV_W = 8;
  localparam int unsigned IDIV_W  = 16;
  localparam int unsigned FDIV_W  = 6;
  localparam int unsigned LINE_W  = 8;
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned FLVL_W  = 6;
  localparam int unsigned DMA_W   = 3;

  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(16'h0300);
  localparam logic [FLVL_W-1:0] FLVL_RST = FLVL_W'(6'h12);

  localparam logic [WORD_W-1:0] W_DATA  = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_STAT  = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_FLAG  = WORD_W'(6);
  localparam logic [WORD_W-1:0] W_LPDIV = WORD_W'(8);
  localparam logic [WORD_W-1:0] W_IDIV  = WORD_W'(9);
  localparam logic [WORD_W-1:0] W_FDIV  = WORD_W'(10);
  localparam logic [WORD_W-1:0] W_LINE  = WORD_W'(11);
  localparam logic [WORD_W-1:0] W_CTRL  = WORD_W'(12);
  localparam logic [WORD_W-1:0] W_FLVL  = WORD_W'(13);
  localparam logic [WORD_W-1:0] W_MASK  = WORD_W'(14);
  localparam logic [WORD_W-1:0] W_RAW   = WORD_W'(15);
  localparam logic [WORD_W-1:0] W_MSKST = WORD_W'(16);
  localparam logic [WORD_W-1:0] W_CLR   = WORD_W'(17);
  localparam logic [WORD_W-1:0] W_DMA   = WORD_W'(18);
  localparam logic [WORD_W-1:0] W_IDBASE = WORD_W'(10'h3F8);

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_STAT, SEL_FLAG, SEL_LPDIV, SEL_IDIV, SEL_FDIV,
    SEL_LINE, SEL_CTRL, SEL_FLVL, SEL_MASK, SEL_RAW, SEL_MSKST, SEL_CLR,
    SEL_DMA, SEL_ID
  } reg_sel_e;

  typedef struct packed {
    logic [DMA_W-1:0]   dma;
    logic [FLVL_W-1:0]  flvl;
    logic [CTRL_W-1:0]  ctrl;
    logic [LINE_W-1:0]  line;
    logic [FDIV_W-1:0]  fdiv;
    logic [IDIV_W-1:0]  idiv;
    logic [LPDIV_W-1:0] lpdiv;
  } cfg_t;

  // byte 0 of each table sits in the low bits
  function automatic logic [7:0] id_byte(input int unsigned set, input logic [2:0] idx);
    logic [63:0] tbl;
    tbl = (set == 1) ? 64'hB105_F00D_0118_0011 : 64'hB105_F00D_0014_1011;
    return tbl[int'(idx)*8 +: 8];
  endfunction

endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
  import uart_regif_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  output reg_sel_e          sel_o,
  output logic [2:0]        id_idx_o,
  output logic              bad_o
);

  logic [WORD_W-1:0] word;
  logic              rd_ok;
  logic              wr_ok;
  logic              unused_lsb;

  assign word       = addr_i[ADDR_W-1:2];
  assign id_idx_o   = addr_i[4:2];
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    sel_o = SEL_NONE;
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    if (word >= W_IDBASE) begin
      sel_o = SEL_ID;
      rd_ok = 1'b1;
    end else begin
      case (word)
        W_DATA:  begin sel_o = SEL_DATA;  rd_ok = 1'b1; wr_ok = 1'b1; end
        W_STAT:  begin sel_o = SEL_STAT;  rd_ok = 1'b1; wr_ok = 1'b1; end
        W_FLAG:  begin sel_o = SEL_FLAG;  rd_ok = 1'b1; wr_ok = 1'b1; end
        W_LPDIV: begin sel_o = SEL_LPDIV; rd_ok = 1'b1; wr_ok = 1'b1; end
        W_IDIV:  begin sel_o = SEL_IDIV;  rd_ok = 1'b1; wr_ok = 1'b1; end
        W_FDIV:  begin sel_o = SEL_FDIV;  rd_ok = 1'b1; wr_ok = 1'b1; end
        W_LINE:  begin sel_o = SEL_LINE;  rd_ok = 1'b1; wr_ok = 1'b1; end
        W_CTRL:  begin sel_o = SEL_CTRL;  rd_ok = 1'b1; wr_ok = 1'b1; end
        W_FLVL:  begin sel_o = SEL_FLVL;  rd_ok = 1'b1; wr_ok = 1'b1; end
        W_MASK:  begin sel_o = SEL_MASK;  rd_ok = 1'b1; wr_ok = 1'b1; end
        W_RAW:   begin sel_o = SEL_RAW;   rd_ok = 1'b1; end
        W_MSKST: begin sel_o = SEL_MSKST; rd_ok = 1'b1; end
        W_CLR:   begin sel_o = SEL_CLR;   wr_ok = 1'b1; end
        W_DMA:   begin sel_o = SEL_DMA;   rd_ok = 1'b1; wr_ok = 1'b1; end
        default: sel_o = SEL_NONE;
      endcase
    end
  end

  assign bad_o = (rd_en_i & ~rd_ok) | (wr_en_i & ~wr_ok);

  // R10: holes never decode as readable
  always_comb begin
    if (rd_en_i && sel_o == SEL_NONE) p_hole_bad_r10: assert (bad_o);
  end

endmodule

// File: rtl/uart_regif_field.sv
module uart_regif_field #(
  parameter int unsigned          W   = 8,
  parameter logic [W-1:0]         RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i;
  end

  p_field_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));

  p_field_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(d_i));

endmodule

// File: rtl/uart_regif_cfg.sv
module uart_regif_cfg
  import uart_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o
);

  logic unused_hi;
  assign unused_hi = ^wdata_i[DATA_W-1:CTRL_W];

  uart_regif_field #(.W(LPDIV_W), .RST('0)) u_lpdiv (
    .clk_i, .rst_ni, .we_i(we_i && sel_i == SEL_LPDIV),
    .d_i(wdata_i[LPDIV_W-1:0]), .q_o(cfg_o.lpdiv));

  uart_regif_field #(.W(IDIV_W), .RST('0)) u_idiv (
    .clk_i, .rst_ni, .we_i(we_i && sel_i == SEL_IDIV),
    .d_i(wdata_i[IDIV_W-1:0]), .q_o(cfg_o.idiv));

  uart_regif_field #(.W(FDIV_W), .RST('0)) u_fdiv (
    .clk_i, .rst_ni, .we_i(we_i && sel_i == SEL_FDIV),
    .d_i(wdata_i[FDIV_W-1:0]), .q_o(cfg_o.fdiv));

  uart_regif_field #(.W(LINE_W), .RST('0)) u_line (
    .clk_i, .rst_ni, .we_i(we_i && sel_i == SEL_LINE),
    .d_i(wdata_i[LINE_W-1:0]), .q_o(cfg_o.line));

  uart_regif_field #(.W(CTRL_W), .RST(CTRL_RST)) u_ctrl (
    .clk_i, .rst_ni, .we_i(we_i && sel_i == SEL_CTRL),
    .d_i(wdata_i[CTRL_W-1:0]), .q_o(cfg_o.ctrl));

  uart_regif_field #(.W(FLVL_W), .RST(FLVL_RST)) u_flvl (
    .clk_i, .rst_ni, .we_i(we_i && sel_i == SEL_FLVL),
    .d_i(wdata_i[FLVL_W-1:0]), .q_o(cfg_o.flvl));

  uart_regif_field #(.W(DMA_W), .RST('0)) u_dma (
    .clk_i, .rst_ni, .we_i(we_i && sel_i == SEL_DMA),
    .d_i(wdata_i[DMA_W-1:0]), .q_o(cfg_o.dma));

endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
  import uart_regif_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic             clr_we_i,
  input  logic [IRQ_W-1:0] wdata_i,
  input  logic             tx_set_i,
  input  logic             rx_set_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_o
);

  logic [IRQ_W-1:0] raw_d;
  logic [IRQ_W-1:0] mask_d;

  // set beats clear so a concurrent event is never lost
  for (genvar b = 0; b < IRQ_W; b++) begin : g_src
    logic set_b;
    if (b == IRQ_RX)      begin : g_rx  assign set_b = rx_set_i; end
    else if (b == IRQ_TX) begin : g_tx  assign set_b = tx_set_i; end
    else                  begin : g_nil assign set_b = 1'b0;     end
    assign raw_d[b] = set_b | (raw_o[b] & ~(clr_we_i & wdata_i[b]));
  end

  assign mask_d = mask_we_i ? wdata_i : mask_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o  <= '0;
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      raw_o  <= raw_d;
      mask_o <= mask_d;
      irq_o  <= |(raw_d & mask_d);
    end
  end

  p_rx_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_set_i |=> raw_o[IRQ_RX]);

  p_tx_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_set_i |=> raw_o[IRQ_TX]);

  p_clear_tx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i && wdata_i[IRQ_TX] && !tx_set_i |=> !raw_o[IRQ_TX]);

  p_mask_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_o == $past(wdata_i));

  p_irq_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((raw_o & mask_o) != '0));

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned ID_SET = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic [7:0]        status_flags_i,
  input  logic              rx_event_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);

  reg_sel_e         sel;
  logic [2:0]       id_idx;
  logic             bad;
  logic             wr_ok;
  logic             dma_err;
  logic             tx_wr;
  cfg_t             cfg;
  logic [IRQ_W-1:0] raw;
  logic [IRQ_W-1:0] mask;

  uart_regif_decode u_decode (
    .addr_i, .rd_en_i, .wr_en_i,
    .sel_o(sel), .id_idx_o(id_idx), .bad_o(bad));

  assign wr_ok   = wr_en_i & ~bad;
  assign tx_wr   = wr_ok && sel == SEL_DATA;
  assign dma_err = wr_ok && sel == SEL_DMA && wdata_i[1:0] != 2'b00;
  assign err_o   = ((rd_en_i | wr_en_i) & bad) | dma_err;

  uart_regif_cfg u_cfg (
    .clk_i, .rst_ni, .we_i(wr_ok), .sel_i(sel), .wdata_i, .cfg_o(cfg));

  uart_regif_irq u_irq (
    .clk_i, .rst_ni,
    .mask_we_i(wr_ok && sel == SEL_MASK),
    .clr_we_i(wr_ok && sel == SEL_CLR),
    .wdata_i(wdata_i[IRQ_W-1:0]),
    .tx_set_i(tx_wr),
    .rx_set_i(rx_event_i),
    .raw_o(raw), .mask_o(mask), .irq_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else if (tx_wr) begin
      tx_valid_o <= 1'b1;
      tx_data_o  <= wdata_i[7:0];
    end else if (tx_ready_i) begin
      tx_valid_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i && !bad) begin
      case (sel)
        SEL_FLAG:  rdata_o = DATA_W'(status_flags_i);
        SEL_LPDIV: rdata_o = DATA_W'(cfg.lpdiv);
        SEL_IDIV:  rdata_o = DATA_W'(cfg.idiv);
        SEL_FDIV:  rdata_o = DATA_W'(cfg.fdiv);
        SEL_LINE:  rdata_o = DATA_W'(cfg.line);
        SEL_CTRL:  rdata_o = DATA_W'(cfg.ctrl);
        SEL_FLVL:  rdata_o = DATA_W'(cfg.flvl);
        SEL_DMA:   rdata_o = DATA_W'(cfg.dma);
        SEL_MASK:  rdata_o = DATA_W'(mask);
        SEL_RAW:   rdata_o = DATA_W'(raw);
        SEL_MSKST: rdata_o = DATA_W'(raw & mask);
        SEL_ID:    rdata_o = DATA_W'(id_byte(ID_SET, id_idx));
        default:   rdata_o = '0;
      endcase
    end
  end

  p_tx_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr |=> tx_valid_o && tx_data_o == $past(wdata_i[7:0]));

  p_tx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !tx_wr |=> tx_valid_o && $stable(tx_data_o));

  p_tx_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && !tx_wr |=> !tx_valid_o);

  p_bad_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && bad |-> rdata_o == '0 && err_o);

  p_dma_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i[ADDR_W-1:2] == W_DMA && wdata_i[1:0] != 2'b00 |-> err_o);

  p_bad_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && bad && !rx_event_i |=> $stable(raw) && $stable(mask) && $stable(cfg));

endmodule

// File: tb/uart_regif_bench.sv
module uart_regif_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;
  logic [7:0]  status_flags_i = 8'h9C;
  logic        rx_event_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        tx_ready_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  uart_regif u_uart_regif (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i, .rdata_o, .err_o,
    .status_flags_i, .rx_event_i, .tx_data_o, .tx_valid_o, .tx_ready_i, .irq_o);

  function automatic logic [11:0] wa(input int word);
    return 12'(word * 4);
  endfunction

  function automatic logic [7:0] exp_id(input int idx);
    logic [7:0] t [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[idx];
  endfunction

  function automatic bit readable(input int w);
    return (w == 0 || w == 1 || w == 6 || (w >= 8 && w <= 16) || w == 18 || w >= 1016);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic e);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    #1 e = err_o;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o; e = err_o;
    @(posedge clk_i);
    #1 rd_en_i = 1'b0;
  endtask

  task automatic rx_pulse();
    @(negedge clk_i); rx_event_i = 1'b1;
    @(negedge clk_i); rx_event_i = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        e;
    int cw [7] = '{8, 9, 10, 11, 12, 13, 18};
    int cb [7] = '{8, 16, 6, 8, 16, 6, 3};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 tx_valid", 32'(tx_valid_o), 0);
    for (int i = 0; i < 7; i++) begin
      rd(wa(cw[i]), d, e);
      chk("R1 cfg reset", d, cw[i] == 12 ? 32'h300 : (cw[i] == 13 ? 32'h12 : 32'h0));
    end
    rd(wa(14), d, e); chk("R1 mask reset", d, 0);
    rd(wa(15), d, e); chk("R1 raw reset", d, 0);

    // R2 config sweep, R10 DMA enable error
    for (int i = 0; i < 7; i++) begin
      for (int p = 0; p < 36; p++) begin
        logic [31:0] pat;
        logic [31:0] msk;
        case (p)
          0: pat = 32'hFFFF_FFFF;
          1: pat = 32'hA5A5_A5A5;
          2: pat = 32'h5A5A_5A5A;
          3: pat = 32'h0;
          default: pat = 32'h1 << (p - 4);
        endcase
        msk = (32'h1 << cb[i]) - 1;
        wr(wa(cw[i]), pat, e);
        chk(cw[i] == 18 ? "R10 dma err" : "R2 write err", 32'(e),
            32'(cw[i] == 18 && pat[1:0] != 2'b00));
        rd(wa(cw[i]), d, e);
        chk("R2 readback", d, pat & msk);
      end
    end

    // cross-register aliasing
    for (int i = 0; i < 7; i++) wr(wa(cw[i]), 32'h4 + 32'(i), e);
    for (int i = 0; i < 7; i++) begin
      rd(wa(cw[i]), d, e);
      chk("R2 no alias", d, (32'h4 + 32'(i)) & ((32'h1 << cb[i]) - 1));
    end

    // R8/R9/R10 full read sweep
    wr(wa(17), 32'hFFFF_FFFF, e);
    wr(wa(14), 32'h0, e);
    for (int w = 0; w < 1024; w++) begin
      rd(wa(w), d, e);
      chk("R10 read err", 32'(e), 32'(!readable(w)));
      if (!readable(w)) chk("R10 bad read zero", d, 0);
      else if (w >= 1016) chk("R8 id byte", d, 32'(exp_id(w - 1016)));
      else if (w <= 1) chk("R9 zero word", d, 0);
      else if (w == 6) chk("R9 flags", d, 32'h9C);
    end

    // R9 flags and status writes ignored
    wr(wa(6), 32'h0, e); chk("R9 flag write err", 32'(e), 0);
    wr(wa(1), 32'hFFFF_FFFF, e); chk("R9 stat write err", 32'(e), 0);
    status_flags_i = 8'h41;
    rd(wa(6), d, e); chk("R9 flags follow input", d, 32'h41);
    rd(wa(1), d, e); chk("R9 stat reads zero", d, 0);

    // R10 bad writes change nothing
    wr(wa(14), 32'h155, e);
    wr(wa(12), 32'h1234, e);
    begin
      int bw [11] = '{2, 3, 4, 5, 7, 15, 16, 19, 100, 1015, 1016};
      for (int i = 0; i < 11; i++) begin
        wr(wa(bw[i]), 32'hFFFF_FFFF, e);
        chk("R10 write err", 32'(e), 1);
      end
    end
    rd(wa(14), d, e); chk("R10 mask kept", d, 32'h155);
    rd(wa(12), d, e); chk("R10 ctrl kept", d, 32'h1234);
    rd(wa(15), d, e); chk("R10 raw kept", d, 0);

    // R3 R4 R5 R7 interrupt sweep
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        wr(wa(17), 32'hFFFF_FFFF, e);
        wr(wa(14), 32'(m) << 4, e);
        if (r[1]) wr(wa(0), 32'h40 + 32'(r), e);
        if (r[0]) rx_pulse();
        rd(wa(15), d, e); chk("R3 R4 raw", d, 32'(r) << 4);
        rd(wa(16), d, e); chk("R5 masked", d, 32'(r & m) << 4);
        rd(wa(14), d, e); chk("R5 mask", d, 32'(m) << 4);
        chk("R7 irq level", 32'(irq_o), 32'((r & m) != 0));
      end
    end

    // R7 one-cycle lag
    wr(wa(17), 32'hFFFF_FFFF, e);
    wr(wa(14), 32'h0, e);
    wr(wa(0), 32'h55, e);
    chk("R7 masked off", 32'(irq_o), 0);
    @(negedge clk_i);
    addr_i = wa(14); wdata_i = 32'h20; wr_en_i = 1'b1;
    #1 chk("R7 before edge", 32'(irq_o), 0);
    @(negedge clk_i); wr_en_i = 1'b0;
    chk("R7 after edge", 32'(irq_o), 1);

    // R6 partial clear and race
    wr(wa(17), 32'hFFFF_FFFF, e);
    wr(wa(0), 32'h11, e);
    rx_pulse();
    wr(wa(17), 32'h20, e);
    rd(wa(15), d, e); chk("R6 partial clear", d, 32'h10);
    @(negedge clk_i);
    addr_i = wa(17); wdata_i = 32'h10; wr_en_i = 1'b1; rx_event_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; rx_event_i = 1'b0;
    rd(wa(15), d, e); chk("R6 rx wins", d, 32'h10);
    wr(wa(17), 32'h10, e);
    rd(wa(15), d, e); chk("R6 full clear", d, 0);

    // R3 handshake
    @(negedge clk_i); tx_ready_i = 1'b1;
    @(negedge clk_i); tx_ready_i = 1'b0;
    chk("R3 drained", 32'(tx_valid_o), 0);
    wr(wa(0), 32'h5566_77C3, e);
    chk("R3 valid", 32'(tx_valid_o), 1);
    chk("R3 byte", 32'(tx_data_o), 32'hC3);
    repeat (3) @(negedge clk_i);
    chk("R3 held", 32'(tx_valid_o), 1);
    chk("R3 byte held", 32'(tx_data_o), 32'hC3);
    @(negedge clk_i); tx_ready_i = 1'b1;
    @(negedge clk_i); tx_ready_i = 1'b0;
    chk("R3 accepted", 32'(tx_valid_o), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule